// File: doc/BRIEF.md
# MDIO Station Management Controller

This block lets a host processor talk to the management registers of an external Ethernet PHY over the two-wire MDC/MDIO management interface (clause 22 framing). The host sees four 32-bit registers behind a simple write strobe and a combinational read port. A transaction starts when the host writes a command word that carries a read or write request together with a 5-bit PHY address and a 5-bit register address. For a write, the value to send is loaded into the data register beforehand. While the frame is being shifted out, a busy flag is raised. When a read finishes, the 16-bit value returned by the PHY is left in the data register.

A control register sets the MDC rate as a divisor of the system clock and can drop the 32-bit preamble for PHYs that accept short frames. It also holds a self-clearing soft reset bit, which aborts any transfer and restores the defaults. MDIO is split into an output, an output enable and an input, so a pad or a model can close the three-state loop outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the busy flag, MDC and the MDIO output enable are 0. The data register reads 0. The control register reads 0x4E00, which is a divisor field of 39 in bits 14:9 with suppression and soft reset both clear.
- R2: Register select 0 is the command register. Setting bit 15 requests a read and setting bit 14 requests a write; when both are set, the read wins. Bits 9:5 give the PHY address and bits 4:0 the register address, and reading the register returns these 10 bits. A command word with neither bit 15 nor bit 14 set starts nothing and leaves the stored command unchanged.
- R3: A frame is sent MSB first in this order: 32 ones of preamble, start bits 01, the opcode (10 for a read, 01 for a write), the PHY address, the register address, a two-bit turnaround and 16 data bits. MDIO only changes while MDC is low.
- R4: For a write, the turnaround is driven as 10 and the data bits are the contents of the data register (select 1) at the moment the command is accepted. The output enable stays high for the whole frame.
- R5: For a read, the output enable falls at the first turnaround bit and stays low until the end of the frame. Each data bit is sampled in the cycle where MDC goes high. When the transaction completes, the data register holds the 16 sampled bits.
- R6: Status register (select 2) bit 0 reads 1 from the cycle after a command is accepted until the final bit period has ended. While this bit is 0, MDC and the output enable are both 0.
- R7: Control register (select 3) bits 14:9 hold the divisor minus one. Each MDC period, and therefore each frame bit, lasts divisor system clocks: MDC is low for the first floor(divisor/2) of them. A field value of 0 behaves as a divisor of 2. The default divisor of 40 gives 2.5 MHz from a 100 MHz clock.
- R8: When control bit 8 is set, the preamble is left out and a frame is 32 MDC periods long instead of 64.
- R9: While busy is set, writes to the command, data and control registers are ignored. The one exception is the control soft reset bit.
- R10: Writing 1 to control bit 0 starts a soft reset. Control bit 0 then reads 1 for RST_CYCLES cycles and clears by itself. The soft reset stops any transaction at once, clears the data register, and restores the divisor and suppression defaults. Register writes made while it is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Writes and reads are driven with several divisors (2 via a zero field, 4, 5 and the default 40), with and without the preamble, and with different PHY data patterns. This separates errors in half-period placement, in odd-divisor handling and in frame length. Command words that set both request bits, or neither, show whether the opcode is chosen in the right order. Writes issued during a transfer and during a soft reset, and a soft reset started in the middle of a read, show whether the lockout and the abort behave as required. Every clock, MDC, MDIO, the output enable and the selected register are compared with a behavioural reference model.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int CMD_RD_BIT    = 15;
    localparam int CMD_WR_BIT    = 14;
    localparam int CTRL_RST_BIT  = 0;
    localparam int CTRL_SUPP_BIT = 8;
    localparam int CTRL_DIV_LSB  = 9;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 14;   // start, opcode, phy, reg
    localparam int TA_END     = 16;   // first data bit index

    typedef struct packed {
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } xact_t;

    function automatic logic [31:0] frame_word(input xact_t x);
        logic [1:0]  op;
        logic [15:0] payload;
        op      = x.is_read ? 2'b10 : 2'b01;
        payload = x.is_read ? 16'h0000 : x.wdata;
        return {2'b01, op, x.phy, x.regad, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_phase.sv
module mdio_phase #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div_eff,
    output logic          mdc,
    output logic          bit_end,
    output logic          rise
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] half;

    assign half    = div_eff >> 1;
    assign bit_end = run && (cnt == div_eff - 1'b1);
    assign rise    = run && (cnt == half);
    assign mdc     = run && (cnt >= half);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (bit_end) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_mgmt_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        abort,
    input  xact_t       xact,
    input  logic        supp,
    input  logic        bit_end,
    input  logic        rise,
    input  logic        mdio_i,
    output logic        busy,
    output logic        rd_commit,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata_nxt
);
    logic [PW-1:0] pos, pre_len, fidx;
    logic [31:0]   word_q;
    logic          rd_q, pre_q, in_pre, last_bit, sample;
    logic [15:0]   shift_q;

    assign pre_len   = pre_q ? PW'(PRE_BITS) : '0;
    assign fidx      = pos - pre_len;
    assign in_pre    = pos < pre_len;
    assign last_bit  = busy && bit_end && (fidx == PW'(FRAME_BITS - 1));
    assign rd_commit = last_bit && rd_q;
    assign sample    = busy && rise && rd_q && !in_pre && (fidx >= PW'(TA_END));
    assign rdata_nxt = sample ? {shift_q[14:0], mdio_i} : shift_q;
    assign mdio_o    = busy && (in_pre || word_q[~fidx[4:0]]);
    assign mdio_oe   = busy && !(rd_q && !in_pre && (fidx >= PW'(HDR_BITS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pos     <= '0;
            word_q  <= '0;
            rd_q    <= 1'b0;
            pre_q   <= 1'b0;
            shift_q <= '0;
        end else begin
            if (start && !busy) begin
                busy    <= 1'b1;
                pos     <= '0;
                word_q  <= frame_word(xact);
                rd_q    <= xact.is_read;
                pre_q   <= !supp;
                shift_q <= '0;
            end else if (busy) begin
                shift_q <= rdata_nxt;
                if (bit_end) begin
                    if (last_bit) busy <= 1'b0;
                    else          pos  <= pos + 1'b1;
                end
            end
            if (abort) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int DIV_DEFAULT = 40,
    parameter int RST_CYCLES  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int DE_W = DIV_W + 1;
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam int PW   = $clog2(PRE_BITS + FRAME_BITS) + 1;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT - 1);

    logic [9:0]       cmd_q;
    logic [15:0]      data_q;
    logic [DIV_W-1:0] div_q;
    logic             supp_q;
    logic [RC_W-1:0]  rst_cnt;
    logic             in_rst, host_ok, accept, soft_go, busy, rd_commit;
    logic             bit_end, rise;
    logic [DE_W-1:0]  div_eff;
    logic [15:0]      rdata_nxt;
    xact_t            xact;
    logic             unused_hi;

    assign unused_hi = ^wr_data[31:16];
    assign in_rst    = rst_cnt != '0;
    assign host_ok   = wr_en && !in_rst;
    assign accept    = host_ok && (wr_addr == SEL_CMD) && !busy &&
                       (wr_data[CMD_RD_BIT] || wr_data[CMD_WR_BIT]);
    assign soft_go   = host_ok && (wr_addr == SEL_CTRL) && wr_data[CTRL_RST_BIT];
    assign div_eff   = (div_q == '0) ? DE_W'(2) : DE_W'(div_q) + 1'b1;

    always_comb begin
        xact.is_read = wr_data[CMD_RD_BIT];
        xact.phy     = wr_data[9:5];
        xact.regad   = wr_data[4:0];
        xact.wdata   = data_q;
    end

    mdio_phase #(.DW(DE_W)) u_phase (
        .clk(clk), .rst(rst), .run(busy), .div_eff(div_eff),
        .mdc(mdc), .bit_end(bit_end), .rise(rise)
    );

    mdio_frame #(.PW(PW)) u_frame (
        .clk(clk), .rst(rst), .start(accept), .abort(soft_go), .xact(xact),
        .supp(supp_q), .bit_end(bit_end), .rise(rise), .mdio_i(mdio_i),
        .busy(busy), .rd_commit(rd_commit), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rdata_nxt(rdata_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            data_q  <= '0;
            div_q   <= DIV_RST;
            supp_q  <= 1'b0;
            rst_cnt <= '0;
        end else begin
            if (in_rst) rst_cnt <= rst_cnt - 1'b1;
            if (accept) cmd_q <= wr_data[9:0];
            if (host_ok && (wr_addr == SEL_DATA) && !busy) data_q <= wr_data[15:0];
            if (host_ok && (wr_addr == SEL_CTRL) && !busy) begin
                div_q  <= wr_data[CTRL_DIV_LSB +: DIV_W];
                supp_q <= wr_data[CTRL_SUPP_BIT];
            end
            if (rd_commit) data_q <= rdata_nxt;
            if (soft_go) begin
                rst_cnt <= RC_W'(RST_CYCLES);
                data_q  <= '0;
                div_q   <= DIV_RST;
                supp_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            SEL_CMD:  rd_data[9:0]  = cmd_q;
            SEL_DATA: rd_data[15:0] = data_q;
            SEL_STAT: rd_data[0]    = busy;
            default: begin
                rd_data[CTRL_DIV_LSB +: DIV_W] = div_q;
                rd_data[CTRL_SUPP_BIT]         = supp_q;
                rd_data[CTRL_RST_BIT]          = in_rst;
            end
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       in_rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [9:0] cmd_q
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == 2'd0);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_hold_while_high_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && mdc) |-> $stable(mdio_o));

    assert_cmd_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd_q));

    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
        in_rst |-> !busy);

    assert_release_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !mdio_oe) |=> (!mdio_oe || !busy));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .in_rst(in_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .cmd_q(cmd_q)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_busy, m_pos, m_cnt, m_D, m_P, m_rd, m_divf, m_supp, m_rst;
    logic [31:0] m_word;
    logic [15:0] m_shift, m_data, phy_val;
    logic [9:0]  m_cmd;

    always @(posedge clk) begin
        int pb, ir;
        if (rst) begin
            m_busy = 0; m_pos = 0; m_cnt = 0; m_D = 2; m_P = 32; m_rd = 0;
            m_word = '0; m_shift = '0; m_data = '0; m_cmd = '0;
            m_divf = 39; m_supp = 0; m_rst = 0;
        end else begin
            pb = m_busy;
            ir = (m_rst != 0);
            if (ir) m_rst--;
            if (m_busy != 0) begin
                if (m_rd != 0 && m_cnt == m_D / 2 && m_pos >= m_P + 16)
                    m_shift = {m_shift[14:0], mdio_i};
                if (m_cnt == m_D - 1) begin
                    m_cnt = 0;
                    if (m_pos == m_P + 31) begin
                        m_busy = 0;
                        if (m_rd != 0) m_data = m_shift;
                    end else m_pos++;
                end else m_cnt++;
            end
            if (wr_en && ir == 0) begin
                case (wr_addr)
                    2'd0: if (pb == 0 && (wr_data[15] || wr_data[14])) begin
                        m_busy = 1; m_pos = 0; m_cnt = 0; m_shift = '0;
                        m_rd = wr_data[15] ? 1 : 0;
                        m_cmd = wr_data[9:0];
                        m_P = (m_supp != 0) ? 0 : 32;
                        m_D = (m_divf == 0) ? 2 : m_divf + 1;
                        m_word = {2'b01, (m_rd != 0) ? 2'b10 : 2'b01, wr_data[9:5], wr_data[4:0],
                                  2'b10, (m_rd != 0) ? 16'h0000 : m_data};
                    end
                    2'd1: if (pb == 0) m_data = wr_data[15:0];
                    2'd3: begin
                        if (pb == 0) begin
                            m_divf = int'(wr_data[14:9]);
                            m_supp = wr_data[8] ? 1 : 0;
                        end
                        if (wr_data[0]) begin
                            m_rst = 8; m_busy = 0; m_data = '0; m_divf = 39; m_supp = 0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, capture of MDIO bits, PHY drive
    logic [63:0] seen;
    int n_rise, n_rel, cyc, last_rise, last_period;
    logic prev_mdc = 1'b0;

    always @(negedge clk) begin
        logic e_mdc, e_oe, e_o;
        logic [31:0] e_rd;
        cyc++;
        if (!rst) begin
            e_mdc = (m_busy != 0) && (m_cnt >= m_D / 2);
            e_oe  = (m_busy != 0) && !(m_rd != 0 && m_pos >= m_P + 14);
            e_o   = (m_busy != 0) && (m_pos < m_P || m_word[31 - (m_pos - m_P)]);
            case (rd_addr)
                2'd0: e_rd = {22'b0, m_cmd};
                2'd1: e_rd = {16'b0, m_data};
                2'd2: e_rd = {31'b0, m_busy != 0};
                default: e_rd = (32'(m_divf) << 9) | (32'(m_supp) << 8) | 32'(m_rst != 0);
            endcase
            chk(mdc == e_mdc, "R7 mdc timing", 32'(mdc), 32'(e_mdc));
            chk(mdio_oe == e_oe, "R5 output enable", 32'(mdio_oe), 32'(e_oe));
            chk(mdio_o == e_o, "R3 mdio value", 32'(mdio_o), 32'(e_o));
            chk(rd_data == e_rd, "R6 register readback", rd_data, e_rd);
            if (mdc && !prev_mdc) begin
                seen = {seen[62:0], mdio_o};
                n_rise++;
                if (!mdio_oe) n_rel++;
                if (last_rise >= 0) last_period = cyc - last_rise;
                last_rise = cyc;
            end
        end
        prev_mdc = mdc;
        if (m_busy != 0 && m_rd != 0 && m_pos >= m_P + 16)
            mdio_i = phy_val[15 - (m_pos - m_P - 16)];
        else
            mdio_i = 1'b1;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); #2;
        rd_addr = a;
        @(negedge clk); #3;
        v = rd_data;
        rd_addr = 2'd2;
    endtask

    task automatic clr_cap();
        seen = '0; n_rise = 0; n_rel = 0; last_rise = -1; last_period = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && m_busy != 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        phy_val = 16'h0000;
        cyc = 0;
        clr_cap();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {mdc, mdio_oe}, 0);
        peek(2'd3, v); chk(v == 32'h0000_4E00, "R1 control default", v, 32'h4E00);
        peek(2'd1, v); chk(v == 0, "R1 data default", v, 0);
        peek(2'd2, v); chk(v == 0, "R1 busy default", v, 0);

        // write, divisor 4, with preamble; lockout while busy
        wr(2'd3, 32'(3) << 9);
        wr(2'd1, 32'h0000_A5C3);
        clr_cap();
        wr(2'd0, (32'd1 << 14) | (32'd5 << 5) | 32'd17);
        chk(rd_data == 32'd1, "R6 busy after accept", rd_data, 1);
        wr(2'd0, (32'd1 << 15) | 32'd3);
        wr(2'd1, 32'h0000_FFFF);
        wr(2'd3, 32'(7) << 9);
        wait_idle();
        chk(n_rise == 64, "R3 frame length", n_rise, 64);
        chk(seen[63:32] == 32'hFFFF_FFFF, "R3 preamble", seen[63:32], 32'hFFFF_FFFF);
        chk(seen[31:0] == {2'b01, 2'b01, 5'd5, 5'd17, 2'b10, 16'hA5C3}, "R4 write frame",
            seen[31:0], {2'b01, 2'b01, 5'd5, 5'd17, 2'b10, 16'hA5C3});
        peek(2'd1, v); chk(v == 32'hA5C3, "R9 data write ignored", v, 32'hA5C3);
        peek(2'd0, v); chk(v == {22'b0, 5'd5, 5'd17}, "R9 command ignored", v, {22'b0, 5'd5, 5'd17});
        peek(2'd3, v); chk(v == (32'(3) << 9), "R9 control ignored", v, 32'(3) << 9);

        // read
        phy_val = 16'hBEEF;
        clr_cap();
        wr(2'd0, (32'd1 << 15) | (32'd1 << 5) | 32'd2);
        wait_idle();
        peek(2'd1, v); chk(v == 32'hBEEF, "R5 read data", v, 32'hBEEF);
        chk(n_rel == 18, "R5 released bits", n_rel, 18);
        chk(seen[29:28] == 2'b10, "R3 read opcode", seen[29:28], 2);
        chk(last_period == 4, "R7 period 4", last_period, 4);

        // both request bits: read wins
        phy_val = 16'h0F0F;
        clr_cap();
        wr(2'd0, 32'h0000_C000 | (32'd3 << 5) | 32'd4);
        wait_idle();
        chk(seen[29:28] == 2'b10, "R2 read priority", seen[29:28], 2);
        peek(2'd1, v); chk(v == 32'h0F0F, "R2 read priority data", v, 32'h0F0F);

        // neither request bit
        wr(2'd0, (32'd2 << 5) | 32'd1);
        chk(rd_data == 0, "R2 no request no busy", rd_data, 0);
        peek(2'd0, v); chk(v == {22'b0, 5'd3, 5'd4}, "R2 command kept", v, {22'b0, 5'd3, 5'd4});

        // preamble suppressed, zero field -> divisor 2
        wr(2'd3, 32'd1 << 8);
        phy_val = 16'h1234;
        clr_cap();
        wr(2'd0, (32'd1 << 15) | (32'd7 << 5) | 32'd9);
        wait_idle();
        chk(n_rise == 32, "R8 short frame", n_rise, 32);
        chk(last_period == 2, "R7 zero field period", last_period, 2);
        peek(2'd1, v); chk(v == 32'h1234, "R8 read data", v, 32'h1234);

        // odd divisor 5, write with all-ones addresses
        wr(2'd3, (32'd4 << 9) | (32'd1 << 8));
        wr(2'd1, 32'h0000_8001);
        clr_cap();
        wr(2'd0, (32'd1 << 14) | (32'd31 << 5) | 32'd31);
        wait_idle();
        chk(seen[31:0] == {2'b01, 2'b01, 5'd31, 5'd31, 2'b10, 16'h8001}, "R4 write frame 2",
            seen[31:0], {2'b01, 2'b01, 5'd31, 5'd31, 2'b10, 16'h8001});
        chk(last_period == 5, "R7 odd period", last_period, 5);

        // soft reset in the middle of a read
        wr(2'd3, 32'(3) << 9);
        phy_val = 16'h7777;
        wr(2'd0, (32'd1 << 15) | 32'd6);
        repeat (30) @(negedge clk);
        wr(2'd3, (32'd7 << 9) | 32'd1);
        chk(rd_data == 0, "R10 abort clears busy", rd_data, 0);
        peek(2'd3, v); chk(v == 32'h0000_4E01, "R10 reset in progress", v, 32'h4E01);
        wr(2'd1, 32'h0000_5555);
        wr(2'd0, (32'd1 << 14) | 32'd1);
        repeat (10) @(negedge clk);
        peek(2'd3, v); chk(v == 32'h0000_4E00, "R10 reset cleared", v, 32'h4E00);
        peek(2'd1, v); chk(v == 0, "R10 data cleared", v, 0);
        peek(2'd2, v); chk(v == 0, "R10 writes during reset ignored", v, 0);

        // default divisor 40 with preamble
        phy_val = 16'hC3A5;
        clr_cap();
        wr(2'd0, (32'd1 << 15) | (32'd2 << 5) | 32'd3);
        wait_idle();
        chk(last_period == 40, "R7 default period", last_period, 40);
        peek(2'd1, v); chk(v == 32'hC3A5, "R5 read at default rate", v, 32'hC3A5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule